// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block keeps a calendar clock (seconds, minutes, hours, weekday, date, month, two-digit year) in packed BCD. It exposes the clock as byte-wide registers in the top sixteen addresses of a byte-addressed space. A one-cycle `tick_i` pulse, normally once per second, advances the time through a carry cascade. The date rolls over according to the length of each month, and February has 29 days in years divisible by four.

Software sets the time with byte writes. Each field is checked as it arrives, and a value that is not valid BCD or falls outside the field's range is dropped without effect. A halt bit held next to the seconds digits freezes the clock, and counting resumes from the held value once the bit is cleared. A century flag sits beside the weekday count but never changes on its own. Reads are combinational from the address. A tick that lands in the same cycle as a write to a time field is carried over to the next cycle instead of being lost.

Top module: `tod_regfile`

## Requirements
- R1: After reset the clock reads 00:00:00, date 0x01, month 0x01, year 0x00, day register 0x00, control 0xA0 cleared and 0x90 set (reads 0x90), halt bit clear.
- R2: The window is the top 16 addresses, and offsets within it are 0x8 control, 0x9 seconds, 0xA minutes, 0xB hours, 0xC day, 0xD date, 0xE month, 0xF year. Offset 0x0 (flags) ignores writes and reads 0x00. Offset 0x1 reads 0x00. All other addresses read 0xFF and ignore writes.
- R3: A tick with the halt bit clear and no time-field write advances seconds by one in BCD. Seconds 59→00 carries into minutes, minutes 59→00 carries into hours, and hours 23→00 carries into the date.
- R4: A date carry wraps the date to 01 after 30 (April, June, September, November), after 31 (other months), and after 28 for February, or 29 when the BCD year is divisible by 4. Month 12→01 carries into the year, year 99→00, and the century flag is untouched.
- R5: The day register reads {0, century, 000, weekday[2:0]}. A write stores bits 2:0 as weekday and bit 6 as century without range checks. Each date carry advances the weekday by one, and values of 6 or more go to 0.
- R6: Seconds and minutes writes use bits 6:0 and are accepted only as valid BCD 00–59. Hours writes use bits 5:0 and are accepted only as valid BCD 00–23. A rejected write leaves the field unchanged.
- R7: Date writes use bits 5:0 (valid BCD 01–31), month writes use bits 4:0 (valid BCD 01–12), and year writes use all 8 bits (valid BCD 00–99). A rejected write leaves the field unchanged.
- R8: Every seconds write stores bit 7 as the halt bit, even when the seconds digits are rejected. While the halt bit is set, ticks are discarded and the time holds. Clearing it resumes from the held value.
- R9: A seconds read returns the halt bit in bit 7 and the BCD seconds in bits 6:0.
- R10: A control write stores (data & 0x5F) | 0x90 and has no other effect.
- R11: A tick in a cycle that writes offsets 0x9–0xF is deferred and takes effect in the first following cycle without such a write. At most one deferred tick is held. A deferred tick is dropped if the halt bit is set when it falls due.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse that advances the time by one second |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
The second tick and a software write to a time field can fall in the same cycle. This collision is forced on purpose: ticks coincide with minute writes, and a second tick arrives while one is already waiting. A long random stream also mixes ticks with writes to every offset. The judging model in the bench keeps its own one-deep deferral flag and discards a deferred tick when the halt bit is set. The bench reads every register after each clock and compares it with the model, so a lost or doubled second shows up in the cycle where it happens.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int unsigned FLD_N   = 6;
  localparam int unsigned FI_SEC  = 0;
  localparam int unsigned FI_MIN  = 1;
  localparam int unsigned FI_HOUR = 2;
  localparam int unsigned FI_DATE = 3;
  localparam int unsigned FI_MON  = 4;
  localparam int unsigned FI_YEAR = 5;

  typedef enum logic [3:0] {
    OFF_FLAG  = 4'h0,
    OFF_SPARE = 4'h1,
    OFF_CTRL  = 4'h8,
    OFF_SEC   = 4'h9,
    OFF_MIN   = 4'hA,
    OFF_HOUR  = 4'hB,
    OFF_DAY   = 4'hC,
    OFF_DATE  = 4'hD,
    OFF_MON   = 4'hE,
    OFF_YEAR  = 4'hF
  } tod_off_e;

  // decoded write request, one cycle wide
  typedef struct packed {
    logic [FLD_N-1:0]      ld;
    logic [FLD_N-1:0][7:0] val;
    logic                  stop_we;
    logic                  stop_val;
    logic                  day_we;
    logic [2:0]            wday_val;
    logic                  cent_val;
    logic                  ctrl_we;
    logic [7:0]            ctrl_val;
    logic                  busy;
  } tod_wr_t;

  function automatic logic bcd_in_range(input logic [7:0] v,
                                        input logic [7:0] lo,
                                        input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10 = 2 mod 4, so tens*10+ones = 2*tens+ones mod 4
  function automatic logic bcd_leap(input logic [7:0] y);
    logic [5:0] s;
    s = 6'({y[7:4], 1'b0}) + 6'(y[3:0]);
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon,
                                           input logic [7:0] yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/tod_bcd_cnt.sv
module tod_bcd_cnt #(
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter logic [7:0] MIN_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_i,
  input  logic [7:0] limit_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);

  logic [7:0] val_q;
  logic [7:0] val_d;
  logic       val_en;

  always_comb begin
    wrap_o = inc_i && (val_q >= limit_i);
    val_en = ld_i || inc_i;
    val_d  = val_q;
    if (ld_i)       val_d = ld_val_i;
    else if (inc_i) val_d = wrap_o ? MIN_VAL : tod_pkg::bcd_step(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= RST_VAL;
    else if (val_en) val_q <= val_d;
  end

  assign val_o = val_q;

endmodule

// File: rtl/tod_wr_decode.sv
module tod_wr_decode
  import tod_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output tod_wr_t           wr_o
);

  localparam int unsigned WIN_W = ADDR_W - 4;

  logic       in_win;
  logic       hit;
  tod_off_e   off;
  logic [7:0] v_sec, v_min, v_hour, v_date, v_mon;

  assign in_win = &addr_i[ADDR_W-1:4];
  assign hit    = wr_en_i && in_win;
  assign off    = tod_off_e'(addr_i[3:0]);

  assign v_sec  = {1'b0, wdata_i[6:0]};
  assign v_min  = {1'b0, wdata_i[6:0]};
  assign v_hour = {2'b0, wdata_i[5:0]};
  assign v_date = {2'b0, wdata_i[5:0]};
  assign v_mon  = {3'b0, wdata_i[4:0]};

  always_comb begin
    wr_o                = '0;
    wr_o.val[FI_SEC]    = v_sec;
    wr_o.val[FI_MIN]    = v_min;
    wr_o.val[FI_HOUR]   = v_hour;
    wr_o.val[FI_DATE]   = v_date;
    wr_o.val[FI_MON]    = v_mon;
    wr_o.val[FI_YEAR]   = wdata_i;
    wr_o.stop_val       = wdata_i[7];
    wr_o.wday_val       = wdata_i[2:0];
    wr_o.cent_val       = wdata_i[6];
    wr_o.ctrl_val       = (wdata_i & 8'h5F) | 8'h90;
    wr_o.busy           = hit && (addr_i[3:0] >= 4'h9);
    if (hit) begin
      case (off)
        OFF_CTRL: wr_o.ctrl_we = 1'b1;
        OFF_SEC: begin
          wr_o.stop_we     = 1'b1;
          wr_o.ld[FI_SEC]  = bcd_in_range(v_sec, 8'h00, 8'h59);
        end
        OFF_MIN:  wr_o.ld[FI_MIN]  = bcd_in_range(v_min, 8'h00, 8'h59);
        OFF_HOUR: wr_o.ld[FI_HOUR] = bcd_in_range(v_hour, 8'h00, 8'h23);
        OFF_DAY:  wr_o.day_we      = 1'b1;
        OFF_DATE: wr_o.ld[FI_DATE] = bcd_in_range(v_date, 8'h01, 8'h31);
        OFF_MON:  wr_o.ld[FI_MON]  = bcd_in_range(v_mon, 8'h01, 8'h12);
        OFF_YEAR: wr_o.ld[FI_YEAR] = bcd_in_range(wdata_i, 8'h00, 8'h99);
        default: ;
      endcase
    end
  end

  // the window test needs at least one address bit above the offset
  if (WIN_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed 4");
  end

endmodule

// File: rtl/tod_rd_mux.sv
module tod_rd_mux
  import tod_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        ctrl_i,
  input  logic              stop_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic              cent_i,
  input  logic [2:0]        wday_i,
  input  logic [7:0]        date_i,
  input  logic [7:0]        mon_i,
  input  logic [7:0]        year_i,
  output logic [7:0]        rdata_o
);

  logic     in_win;
  tod_off_e off;

  assign in_win = &addr_i[ADDR_W-1:4];
  assign off    = tod_off_e'(addr_i[3:0]);

  always_comb begin
    rdata_o = 8'hFF;
    if (in_win) begin
      case (off)
        OFF_FLAG:  rdata_o = 8'h00;
        OFF_SPARE: rdata_o = 8'h00;
        OFF_CTRL:  rdata_o = ctrl_i;
        OFF_SEC:   rdata_o = {stop_i, sec_i[6:0]};
        OFF_MIN:   rdata_o = min_i;
        OFF_HOUR:  rdata_o = hour_i;
        OFF_DAY:   rdata_o = {1'b0, cent_i, 3'b000, wday_i};
        OFF_DATE:  rdata_o = date_i;
        OFF_MON:   rdata_o = mon_i;
        OFF_YEAR:  rdata_o = year_i;
        default:   rdata_o = 8'hFF;
      endcase
    end
  end

endmodule

// File: rtl/tod_regfile.sv
module tod_regfile
  import tod_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam logic [7:0] CTRL_RST = 8'h90;
  localparam logic [2:0] WDAY_TOP = 3'd6;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // write decode
  tod_wr_t wr;

  tod_wr_decode #(.ADDR_W(ADDR_W)) u_wr_decode (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_o    (wr)
  );

  // tick scheduling
  logic stop_q, stop_d, stop_en;
  logic pend_q, pend_d;
  logic tick_due, adv;

  always_comb begin
    tick_due = tick_i | pend_q;
    adv      = tick_due & ~wr.busy & ~stop_q;
    pend_d   = tick_due &  wr.busy & ~stop_q;
    stop_en  = wr.stop_we;
    stop_d   = wr.stop_val;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (stop_en) stop_q <= stop_d;
    end
  end

  // counter cascade: sec -> min -> hour -> date -> month -> year
  logic [FLD_N-1:0][7:0] fld_val;
  logic [FLD_N-1:0][7:0] fld_lim;
  logic [FLD_N-1:0]      fld_inc;
  logic [FLD_N-1:0]      fld_wrap;

  assign fld_inc = {fld_wrap[FLD_N-2:0], adv};

  always_comb begin
    fld_lim          = '0;
    fld_lim[FI_SEC]  = 8'h59;
    fld_lim[FI_MIN]  = 8'h59;
    fld_lim[FI_HOUR] = 8'h23;
    fld_lim[FI_DATE] = month_len(fld_val[FI_MON], fld_val[FI_YEAR]);
    fld_lim[FI_MON]  = 8'h12;
    fld_lim[FI_YEAR] = 8'h99;
  end

  for (genvar g = 0; g < FLD_N; g++) begin : g_fld
    localparam logic [7:0] BASE_V =
      ((g == FI_DATE) || (g == FI_MON)) ? 8'h01 : 8'h00;
    tod_bcd_cnt #(
      .RST_VAL (BASE_V),
      .MIN_VAL (BASE_V)
    ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_ni),
      .inc_i    (fld_inc[g]),
      .limit_i  (fld_lim[g]),
      .ld_i     (wr.ld[g]),
      .ld_val_i (wr.val[g]),
      .val_o    (fld_val[g]),
      .wrap_o   (fld_wrap[g])
    );
  end

  // weekday, century and control
  logic [2:0] wday_q, wday_d;
  logic       wday_en;
  logic       cent_q, cent_d, cent_en;
  logic [7:0] ctrl_q, ctrl_d;
  logic       ctrl_en;

  always_comb begin
    wday_en = wr.day_we | fld_wrap[FI_HOUR];
    if (wr.day_we)              wday_d = wr.wday_val;
    else if (wday_q >= WDAY_TOP) wday_d = 3'd0;
    else                        wday_d = wday_q + 3'd1;
    cent_en = wr.day_we;
    cent_d  = wr.cent_val;
    ctrl_en = wr.ctrl_we;
    ctrl_d  = wr.ctrl_val;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wday_q <= 3'd0;
      cent_q <= 1'b0;
      ctrl_q <= CTRL_RST;
    end else begin
      if (wday_en) wday_q <= wday_d;
      if (cent_en) cent_q <= cent_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  // read path
  tod_rd_mux #(.ADDR_W(ADDR_W)) u_rd_mux (
    .addr_i  (addr_i),
    .ctrl_i  (ctrl_q),
    .stop_i  (stop_q),
    .sec_i   (fld_val[FI_SEC]),
    .min_i   (fld_val[FI_MIN]),
    .hour_i  (fld_val[FI_HOUR]),
    .cent_i  (cent_q),
    .wday_i  (wday_q),
    .date_i  (fld_val[FI_DATE]),
    .mon_i   (fld_val[FI_MON]),
    .year_i  (fld_val[FI_YEAR]),
    .rdata_o (rdata_o)
  );

  // taps for the bound checker
  logic [7:0] sec_v, date_v;
  logic       busy_w, ld_sec_w;
  assign sec_v    = fld_val[FI_SEC];
  assign date_v   = fld_val[FI_DATE];
  assign busy_w   = wr.busy;
  assign ld_sec_w = wr.ld[FI_SEC];

endmodule

// File: rtl/tod_regfile_chk.sv
module tod_regfile_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic              busy,
  input logic              ld_sec,
  input logic              stop_q,
  input logic [7:0]        sec,
  input logic [7:0]        date,
  input logic [7:0]        ctrl,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o
);

  a_r3_sec_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[3:0] <= 4'd9) && (sec <= 8'h59));

  a_r3_sec_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (sec != 8'h59)) |=> (sec != $past(sec)));

  a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !busy) |=> $stable(sec));

  a_r11_write_holds_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_sec) |=> $stable(sec));

  a_r10_ctrl_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[7] && ctrl[4] && !ctrl[5]);

  a_r4_date_range: assert property (@(posedge clk) disable iff (!rst_n)
    (date >= 8'h01) && (date <= 8'h31) && (date[3:0] <= 4'd9));

  a_r2_spare_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((&addr_i[ADDR_W-1:4]) && (addr_i[3:0] == 4'h1)) |-> (rdata_o == 8'h00));

endmodule

bind tod_regfile tod_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_ni),
  .adv     (adv),
  .busy    (busy_w),
  .ld_sec  (ld_sec_w),
  .stop_q  (stop_q),
  .sec     (sec_v),
  .date    (date_v),
  .ctrl    (ctrl_q),
  .addr_i  (addr_i),
  .rdata_o (rdata_o)
);

// File: tb/tod_regfile_bench.sv
`timescale 1ns/1ps
module tod_regfile_bench;

  localparam int AW   = 13;
  localparam int BASE = (1 << AW) - 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;

  always #5 clk = ~clk;

  tod_regfile #(.ADDR_W(AW)) u_tod_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // behavioural model, plain integers
  int m_sec, m_min, m_hr, m_wday, m_cent, m_date, m_mon, m_yr;
  int m_stop, m_ctrl, m_pend;

  function automatic int bcd(int x);
    return ((x / 10) << 4) | (x % 10);
  endfunction

  function automatic bit dec_ok(int v, int lo, int hi, output int n);
    n = (v >> 4) * 10 + (v & 15);
    return ((v & 15) <= 9) && (n >= lo) && (n <= hi);
  endfunction

  function automatic int mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic string tag_of(int off);
    case (off)
      0, 1:       return "R2";
      8:          return "R10";
      9:          return "R9";
      10, 11:     return "R3";
      12:         return "R5";
      default:    return "R4";
    endcase
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_wday = 0; m_cent = 0;
    m_date = 1; m_mon = 1; m_yr = 0; m_stop = 0; m_ctrl = 'h90; m_pend = 0;
  endtask

  function automatic int model_read(int off);
    case (off)
      0, 1: return 0;
      8:    return m_ctrl;
      9:    return (m_stop << 7) | bcd(m_sec);
      10:   return bcd(m_min);
      11:   return bcd(m_hr);
      12:   return (m_cent << 6) | m_wday;
      13:   return bcd(m_date);
      14:   return bcd(m_mon);
      15:   return bcd(m_yr);
      default: return 255;
    endcase
  endfunction

  task automatic model_advance();
    if (m_sec < 59) begin m_sec++; return; end
    m_sec = 0;
    if (m_min < 59) begin m_min++; return; end
    m_min = 0;
    if (m_hr < 23) begin m_hr++; return; end
    m_hr = 0;
    m_wday = (m_wday >= 6) ? 0 : m_wday + 1;
    if (m_date < mlen(m_mon, m_yr)) begin m_date++; return; end
    m_date = 1;
    if (m_mon < 12) begin m_mon++; return; end
    m_mon = 1;
    m_yr = (m_yr >= 99) ? 0 : m_yr + 1;
  endtask

  task automatic model_step(bit t, bit w, int a, int d);
    bit inwin, busy, due, adv;
    int off, n;
    inwin = (a >= BASE) && (a < BASE + 16);
    off   = a - BASE;
    busy  = w && inwin && (off >= 9);
    due   = t || (m_pend != 0);
    adv   = due && !busy && (m_stop == 0);
    m_pend = (due && busy && (m_stop == 0)) ? 1 : 0;
    if (w && inwin) begin
      case (off)
        8:  m_ctrl = (d & 'h5F) | 'h90;
        9:  begin
              if (dec_ok(d & 'h7F, 0, 59, n)) m_sec = n;
              m_stop = (d >> 7) & 1;
            end
        10: if (dec_ok(d & 'h7F, 0, 59, n)) m_min = n;
        11: if (dec_ok(d & 'h3F, 0, 23, n)) m_hr = n;
        12: begin m_wday = d & 7; m_cent = (d >> 6) & 1; end
        13: if (dec_ok(d & 'h3F, 1, 31, n)) m_date = n;
        14: if (dec_ok(d & 'h1F, 1, 12, n)) m_mon = n;
        15: if (dec_ok(d & 'hFF, 0, 99, n)) m_yr = n;
        default: ;
      endcase
    end
    if (adv) model_advance();
  endtask

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // read every register and compare with the model
  task automatic sweep();
    for (int o = 0; o < 16; o++) begin
      if (o < 2 || o >= 8) begin
        addr = AW'(BASE + o);
        #0.2;
        check(tag_of(o), int'(rdata), model_read(o));
      end
    end
    addr = AW'('h0123);
    #0.2;
    check("R2", int'(rdata), 255);
  endtask

  task automatic expect_reg(int off, int exp, string tag);
    addr = AW'(BASE + off);
    #0.2;
    check(tag, int'(rdata), exp);
  endtask

  task automatic cyc(bit t, bit w, int a, int d);
    tick = t; wr_en = w; addr = AW'(a); wdata = 8'(d);
    @(posedge clk);
    model_step(t, w, a, d);
    #1;
    tick = 1'b0; wr_en = 1'b0;
    sweep();
  endtask

  task automatic wr(int off, int d);
    cyc(1'b0, 1'b1, BASE + off, d);
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, BASE + 9, 0);
  endtask

  task automatic set_eod();
    wr(11, 'h23); wr(10, 'h59); wr(9, 'h59);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    sweep();
    expect_reg(9, 'h00, "R1");
    expect_reg(13, 'h01, "R1");
    expect_reg(14, 'h01, "R1");
    expect_reg(8, 'h90, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, BASE + 9, 0);

    // R3 plain counting
    tk(3);
    expect_reg(9, 'h03, "R3");

    // R4 non-leap February
    wr(15, 'h23); wr(14, 'h02); wr(13, 'h28); set_eod(); tk(1);
    expect_reg(13, 'h01, "R4"); expect_reg(14, 'h03, "R4");

    // R4 leap February
    wr(15, 'h24); wr(14, 'h02); wr(13, 'h28); set_eod(); tk(1);
    expect_reg(13, 'h29, "R4");
    set_eod(); tk(1);
    expect_reg(13, 'h01, "R4"); expect_reg(14, 'h03, "R4");

    // R4 R5 year end, weekday wrap, century kept
    wr(15, 'h99); wr(14, 'h12); wr(13, 'h31); wr(12, 'h46);
    expect_reg(12, 'h46, "R5");
    set_eod(); tk(1);
    expect_reg(15, 'h00, "R4"); expect_reg(14, 'h01, "R4");
    expect_reg(12, 'h40, "R5"); expect_reg(11, 'h00, "R3");

    // R4 thirty-day month
    wr(14, 'h04); wr(13, 'h30); set_eod(); tk(1);
    expect_reg(14, 'h05, "R4"); expect_reg(13, 'h01, "R4");

    // R6 R7 rejected and masked writes
    wr(9, 'h12); wr(10, 'h34); wr(11, 'h15);
    wr(13, 'h17); wr(14, 'h06); wr(15, 'h42);
    wr(9, 'h60); wr(9, 'h5A); wr(10, 'h7F); wr(11, 'h24); wr(11, 'h1A);
    expect_reg(9, 'h12, "R6"); expect_reg(10, 'h34, "R6"); expect_reg(11, 'h15, "R6");
    wr(11, 'hE2);
    expect_reg(11, 'h22, "R6");
    wr(13, 'h00); wr(13, 'h32); wr(14, 'h00); wr(14, 'h13); wr(14, 'h0A);
    wr(15, 'h9A); wr(15, 'hA0);
    expect_reg(13, 'h17, "R7"); expect_reg(14, 'h06, "R7"); expect_reg(15, 'h42, "R7");
    wr(13, 'hC9); wr(14, 'hE9);
    expect_reg(13, 'h09, "R7"); expect_reg(14, 'h09, "R7");

    // R8 halt and resume
    wr(9, 'h85); tk(4);
    expect_reg(9, 'h85, "R8");
    wr(9, 'h7F);
    expect_reg(9, 'h05, "R8");
    tk(1);
    expect_reg(9, 'h06, "R8");

    // R10 control formatting
    wr(8, 'hFF); expect_reg(8, 'hDF, "R10");
    wr(8, 'h00); expect_reg(8, 'h90, "R10");

    // R2 flags, spare and outside writes ignored
    wr(0, 'hAA); expect_reg(0, 'h00, "R2");
    wr(1, 'h55); expect_reg(1, 'h00, "R2");
    cyc(1'b0, 1'b1, 'h0123, 'h77);
    expect_reg(9, 'h06, "R2");

    // R11 tick meeting a write is deferred, one deep
    wr(9, 'h10);
    cyc(1'b1, 1'b1, BASE + 10, 'h30);
    expect_reg(9, 'h10, "R11"); expect_reg(10, 'h30, "R11");
    cyc(1'b0, 1'b0, BASE + 9, 0);
    expect_reg(9, 'h11, "R11");
    cyc(1'b1, 1'b1, BASE + 10, 'h31);
    cyc(1'b1, 1'b0, BASE + 9, 0);
    cyc(1'b0, 1'b0, BASE + 9, 0);
    expect_reg(9, 'h12, "R11");
    // deferred tick dropped when halt is set meanwhile
    cyc(1'b1, 1'b1, BASE + 9, 'h95);
    cyc(1'b0, 1'b0, BASE + 9, 0);
    expect_reg(9, 'h95, "R11");
    wr(9, 'h15);

    // mixed random traffic, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      int r, off, d, a;
      bit t, w;
      r   = int'($urandom % 16);
      t   = ($urandom % 2) == 1;
      w   = r < 5;
      off = int'($urandom % 16);
      case ($urandom % 6)
        0:       d = 'h59;
        1:       d = 'h23;
        2:       d = 'h28 + int'($urandom % 4);
        3:       d = 'h12;
        default: d = int'($urandom % 256);
      endcase
      if (off == 9 && ($urandom % 4) != 0) d = d & 'h7F;
      a = (r == 15) ? int'($urandom % BASE) : BASE + off;
      cyc(t, w, a, d);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule